// File: doc/BRIEF.md
# Dual-Edge PDM Microphone Demultiplexer

This block collects one-bit pulse-density bitstreams from as many as four microphones. The microphones share two data lines and one bit clock that the block generates itself. On each data line, one microphone drives its bit while the bit clock is high and another drives its bit while the clock is low. That gives four microphone slots: two lines, each sampled in two half periods. The bit clock is always produced here by dividing the system clock. The block never accepts a bit clock from outside.

Each logical channel has a routing field in a static configuration word. The field picks the data line and the clock edge that feed the channel. A per-channel enable mask decides which channels deliver samples. Once per bit-clock period, all enabled channels present their new bit together with a one-cycle valid strobe, ready for a downstream decimation filter. A synchronous software-reset input clears all capture state in one cycle.

Top module: `pdm_mic_demux`

## Requirements
- R1: While `rst` is high, and on the cycle after a clock edge at which it was high, `bclk_out`, every `smp_valid` bit and every `smp_bit` bit are 0.
- R2: `bclk_out` has a period of `DIV_RATIO` system cycles, split into a high phase and a low phase of `DIV_RATIO/2` cycles each. After any reset it starts with a low phase.
- R3: The rising-edge slot of a data line is its level at the system clock edge on which `bclk_out` goes from 0 to 1. The falling-edge slot is its level at the system clock edge on which `bclk_out` goes from 1 to 0.
- R4: For channel `c`, bit `2*c` of `route_cfg` chooses the edge (0 = rising-edge slot, 1 = falling-edge slot). Bit `2*c+16` chooses the line (0 = `pdm_din[0]`, 1 = `pdm_din[1]`). Several channels may pick the same slot. All other bits of `route_cfg` have no effect.
- R5: All channel outputs update together, one system cycle after the edge on which `bclk_out` rises. That frame carries the rising-edge slot taken at that edge and the falling-edge slot taken at the end of the high phase just before it.
- R6: An enabled channel raises `smp_valid[c]` for exactly one system cycle per bit-clock period, and only if `ch_enable[c]` is 1 at the rising edge of `bclk_out` that closes the frame.
- R7: A channel whose enable bit is 0 at a frame gives no valid strobe, and its `smp_bit` is driven to 0. Clearing one enable bit takes effect at the next frame and leaves the other channels' bits and strobes unchanged.
- R8: The first rising edge of `bclk_out` after a reset or software reset produces no frame, because no falling-edge slot has yet been sampled. The first strobe follows the second rising edge.
- R9: When `soft_rst` is high at a clock edge, the block returns to its reset state at that edge: `bclk_out` low, all strobes and bits 0, divider restarted at the low phase, and stored slot samples and the primed state cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous software reset pulse, clears all capture state |
| route_cfg | input | 32 | Static routing word: edge select at bit 2*c, line select at bit 2*c+16 |
| ch_enable | input | N_CH | Per-channel enable mask, bit c for channel c |
| pdm_din | input | 2 | The two shared microphone data lines |
| bclk_out | output | 1 | Generated microphone bit clock |
| smp_bit | output | N_CH | Latest one-bit sample of each channel |
| smp_valid | output | N_CH | One-cycle strobe per channel marking a new sample |

## Verification
A channel's sample is due exactly one system cycle after the edge on which `bclk_out` rises. The bench therefore watches `bclk_out` on falling clock edges, notes the negedge where it first reads high, and checks the outputs at the very next negedge. It checks again one negedge later to confirm that the strobe has dropped. Each line's level is changed only on a negedge and then held for a whole half period, so each slot value is fixed before the edge that samples it. A software reset is checked on the negedge right after the edge that applied it. The suppressed first frame is checked on every negedge of the first high phase.

// File: rtl/pdm_demux_pkg.sv
package pdm_demux_pkg;

    // Architectural limits of the demultiplexer
    localparam int PDM_MAX_CH     = 4;
    localparam int PDM_LINES      = 2;
    localparam int ROUTE_CFG_W    = 32;
    localparam int EDGE_SEL_BASE  = 0;   // edge select of channel c at 2*c
    localparam int LINE_SEL_BASE  = 16;  // line select of channel c at 2*c+16

    // Which half of the bit period supplies a channel
    typedef enum logic {
        SLOT_RISE = 1'b0,
        SLOT_FALL = 1'b1
    } slot_edge_e;

    // Decoded routing of one logical channel
    typedef struct packed {
        logic       line_sel;
        slot_edge_e edge_sel;
    } ch_route_t;

    // Divider events, valid for the coming clock edge
    typedef struct packed {
        logic rise_evt;
        logic fall_evt;
    } bclk_evt_t;

    // One complete bit period of both lines, released on one strobe
    typedef struct packed {
        logic [PDM_LINES-1:0] rise_bits;
        logic [PDM_LINES-1:0] fall_bits;
        logic                 stb;
    } pdm_frame_t;

    // Extract the routing field of channel ch from the configuration word
    function automatic ch_route_t decode_route(input logic [ROUTE_CFG_W-1:0] cfg,
                                               input int ch);
        ch_route_t r;
        r.edge_sel = slot_edge_e'(cfg[EDGE_SEL_BASE + 2*ch]);
        r.line_sel = cfg[LINE_SEL_BASE + 2*ch];
        return r;
    endfunction

    // Choose the slot a route points at from a captured frame
    function automatic logic pick_slot(input pdm_frame_t f, input ch_route_t r);
        logic [PDM_LINES-1:0] half_bits;
        half_bits = (r.edge_sel == SLOT_FALL) ? f.fall_bits : f.rise_bits;
        return half_bits[r.line_sel];
    endfunction

endpackage

// File: rtl/pdm_bclk_gen.sv
module pdm_bclk_gen
    import pdm_demux_pkg::*;
#(
    parameter int DIV_RATIO = 8   // even, at least 4
) (
    input  logic      clk,
    input  logic      clr,
    output logic      bclk,
    output bclk_evt_t evt
);

    localparam int CNT_W = $clog2(DIV_RATIO);
    localparam int HALF  = DIV_RATIO / 2;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(DIV_RATIO - 1);
    localparam logic [CNT_W-1:0] CNT_HALF  = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] CNT_FALL  = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             bclk_q;

    // cnt 0..HALF-1 is the high phase, HALF..DIV_RATIO-1 the low phase
    always_comb begin
        evt.rise_evt = (cnt_q == CNT_LAST);
        evt.fall_evt = (cnt_q == CNT_FALL);
        cnt_nx       = evt.rise_evt ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q  <= CNT_HALF;   // restart at the low phase
            bclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            bclk_q <= (cnt_nx < CNT_HALF);
        end
    end

    assign bclk = bclk_q;

endmodule

// File: rtl/pdm_slot_capture.sv
module pdm_slot_capture
    import pdm_demux_pkg::*;
(
    input  logic                 clk,
    input  logic                 clr,
    input  logic [PDM_LINES-1:0] pdm_din,
    input  bclk_evt_t            evt,
    output pdm_frame_t           frame
);

    logic [PDM_LINES-1:0] fall_hold_q;
    logic                 primed_q;
    pdm_frame_t           frame_q;

    // The falling-edge slot is parked until the rising edge closes the
    // period, so both halves leave on a single strobe.
    always_ff @(posedge clk) begin
        if (clr) begin
            fall_hold_q <= '0;
            primed_q    <= 1'b0;
            frame_q     <= '0;
        end else begin
            frame_q.stb <= 1'b0;
            if (evt.fall_evt) begin
                fall_hold_q <= pdm_din;
                primed_q    <= 1'b1;
            end
            if (evt.rise_evt) begin
                frame_q.rise_bits <= pdm_din;
                frame_q.fall_bits <= fall_hold_q;
                frame_q.stb       <= primed_q;
            end
        end
    end

    assign frame = frame_q;

endmodule

// File: rtl/pdm_chan_route.sv
module pdm_chan_route
    import pdm_demux_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  ch_route_t  route,
    input  logic       enable,
    input  pdm_frame_t frame,
    output logic       bit_o,
    output logic       vld_o
);

    logic bit_q;
    logic vld_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= frame.stb & enable;
            if (frame.stb) begin
                bit_q <= enable ? pick_slot(frame, route) : 1'b0;
            end
        end
    end

    assign bit_o = bit_q;
    assign vld_o = vld_q;

endmodule

// File: rtl/pdm_mic_demux.sv
module pdm_mic_demux
    import pdm_demux_pkg::*;
#(
    parameter int N_CH      = 4,   // 1..PDM_MAX_CH
    parameter int DIV_RATIO = 8    // even, at least 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_rst,
    input  logic [ROUTE_CFG_W-1:0] route_cfg,
    input  logic [N_CH-1:0]        ch_enable,
    input  logic [PDM_LINES-1:0]   pdm_din,
    output logic                   bclk_out,
    output logic [N_CH-1:0]        smp_bit,
    output logic [N_CH-1:0]        smp_valid
);

    logic       clr;
    bclk_evt_t  evt;
    pdm_frame_t frame;
    logic       unused_cfg;

    assign clr        = rst | soft_rst;
    assign unused_cfg = ^route_cfg;

    pdm_bclk_gen #(
        .DIV_RATIO (DIV_RATIO)
    ) i_bclk (
        .clk  (clk),
        .clr  (clr),
        .bclk (bclk_out),
        .evt  (evt)
    );

    pdm_slot_capture i_capture (
        .clk     (clk),
        .clr     (clr),
        .pdm_din (pdm_din),
        .evt     (evt),
        .frame   (frame)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        ch_route_t route;
        assign route = decode_route(route_cfg, ch);

        pdm_chan_route i_route (
            .clk    (clk),
            .clr    (clr),
            .route  (route),
            .enable (ch_enable[ch]),
            .frame  (frame),
            .bit_o  (smp_bit[ch]),
            .vld_o  (smp_valid[ch])
        );
    end

endmodule

// File: rtl/pdm_mic_demux_chk.sv
module pdm_mic_demux_chk #(
    parameter int N_CH      = 4,
    parameter int DIV_RATIO = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            soft_rst,
    input logic [N_CH-1:0] ch_enable,
    input logic            bclk_out,
    input logic [N_CH-1:0] smp_bit,
    input logic [N_CH-1:0] smp_valid
);

    localparam int HALF  = DIV_RATIO / 2;
    localparam int RUN_W = $clog2(DIV_RATIO) + 1;

    // Length of the current bclk phase, counted in sampled edges
    logic             prev_q;
    logic             armed_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            prev_q  <= 1'b1;   // first post-clear sample reads as a change
            armed_q <= 1'b0;
            run_q   <= '0;
        end else begin
            prev_q <= bclk_out;
            if (bclk_out != prev_q) begin
                run_q   <= '0;
                armed_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    AST_BCLK_PHASE_MAX: assert property (@(posedge clk) disable iff (rst || soft_rst)
        run_q < RUN_W'(HALF)); // R2

    AST_BCLK_PHASE_EXACT: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (armed_q && (bclk_out != prev_q)) |-> (run_q == RUN_W'(HALF - 1))); // R2

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|smp_valid) |=> (smp_valid == '0)); // R6

    AST_STROBE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (|smp_valid) |-> ((smp_valid & ~$past(ch_enable)) == '0)); // R7

    AST_STROBE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        (|smp_valid) |-> (bclk_out && $past(bclk_out) && !$past(bclk_out, 2))); // R5

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!bclk_out && (smp_valid == '0) && (smp_bit == '0))); // R9

endmodule

bind pdm_mic_demux pdm_mic_demux_chk #(
    .N_CH      (N_CH),
    .DIV_RATIO (DIV_RATIO)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .ch_enable (ch_enable),
    .bclk_out  (bclk_out),
    .smp_bit   (smp_bit),
    .smp_valid (smp_valid)
);

// File: tb/test_pdm_mic_demux.sv
`timescale 1ns/1ps
module test_pdm_mic_demux;

    localparam int BENCH_DIV = 8;
    localparam int HALF      = BENCH_DIV / 2;
    localparam int NCH       = 4;
    localparam int NVEC      = 8;

    // {edge[3:0], line[3:0], enable[3:0], hi_level[1:0], lo_level[1:0], expected_bits[3:0]}
    // hi_level is held on the lines during the high phase (falling-edge slot),
    // lo_level during the low phase (rising-edge slot).
    localparam logic [19:0] VEC [NVEC] = '{
        {4'b1010, 4'b1100, 4'b1111, 2'b01, 2'b10, 4'b0110},
        {4'b1010, 4'b1100, 4'b1111, 2'b10, 2'b01, 4'b1001},
        {4'b0000, 4'b0000, 4'b1111, 2'b00, 2'b11, 4'b1111},
        {4'b1111, 4'b1111, 4'b1111, 2'b10, 2'b01, 4'b1111},
        {4'b1111, 4'b0000, 4'b1111, 2'b10, 2'b01, 4'b0000},
        {4'b1010, 4'b1100, 4'b0101, 2'b01, 2'b10, 4'b0100},
        {4'b0101, 4'b0011, 4'b1111, 2'b11, 2'b00, 4'b0101},
        {4'b0000, 4'b1010, 4'b1010, 2'b00, 2'b10, 4'b1010}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            soft_rst;
    logic [31:0]     route_cfg;
    logic [NCH-1:0]  ch_enable;
    logic [1:0]      pdm_din;
    logic            bclk_out;
    logic [NCH-1:0]  smp_bit;
    logic [NCH-1:0]  smp_valid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pdm_mic_demux #(
        .N_CH      (NCH),
        .DIV_RATIO (BENCH_DIV)
    ) i_pdm_mic_demux (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .route_cfg (route_cfg),
        .ch_enable (ch_enable),
        .pdm_din   (pdm_din),
        .bclk_out  (bclk_out),
        .smp_bit   (smp_bit),
        .smp_valid (smp_valid)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_bclk(input logic lvl);
        do @(negedge clk); while (bclk_out !== lvl);
    endtask

    // Odd bit positions carry no routing field and are always set (R4)
    function automatic logic [31:0] make_cfg(input logic [3:0] edg, input logic [3:0] line);
        logic [31:0] cfg;
        cfg = 32'hAAAA_AAAA;
        for (int c = 0; c < NCH; c++) begin
            cfg[2*c]      = edg[c];
            cfg[2*c + 16] = line[c];
        end
        return cfg;
    endfunction

    // Runs one bit period from inside a high phase and checks its frame
    task automatic run_vec(input logic [19:0] v, input int idx);
        logic [3:0] edg, line, en, exp_bits;
        logic [1:0] hi, lo;
        {edg, line, en, hi, lo, exp_bits} = v;
        route_cfg = make_cfg(edg, line);
        ch_enable = en;
        pdm_din   = hi;
        wait_bclk(1'b0);
        pdm_din   = lo;
        wait_bclk(1'b1);
        @(negedge clk);
        check(smp_bit === exp_bits, $sformatf("R3 R4 R5 R7 vec%0d bits", idx),
              32'(smp_bit), 32'(exp_bits));
        check(smp_valid === en, $sformatf("R6 R7 vec%0d valid", idx),
              32'(smp_valid), 32'(en));
        @(negedge clk);
        check(smp_valid === '0, $sformatf("R6 vec%0d strobe width", idx),
              32'(smp_valid), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int  nh;
        int  nl;
        bit  early_strobe;
        rst       = 1'b1;
        soft_rst  = 1'b0;
        route_cfg = 32'h0;
        ch_enable = '1;
        pdm_din   = 2'b00;
        repeat (3) @(negedge clk);

        // R1: reset state
        check(bclk_out === 1'b0, "R1 bclk in reset", 32'(bclk_out), 32'h0);
        check(smp_valid === '0, "R1 valid in reset", 32'(smp_valid), 32'h0);
        check(smp_bit === '0, "R1 bits in reset", 32'(smp_bit), 32'h0);
        rst = 1'b0;

        // R2 phase lengths and R8 suppressed first frame
        early_strobe = 1'b0;
        wait_bclk(1'b1);
        nh = 1;
        forever begin
            @(negedge clk);
            if (bclk_out !== 1'b1) break;
            nh++;
            if (smp_valid !== '0) early_strobe = 1'b1;
        end
        nl = 1;
        forever begin
            @(negedge clk);
            if (bclk_out !== 1'b0) break;
            nl++;
        end
        check(nh == HALF, "R2 high phase length", 32'(nh), 32'(HALF));
        check(nl == HALF, "R2 low phase length", 32'(nl), 32'(HALF));
        check(!early_strobe, "R8 no frame at first rise", 32'(early_strobe), 32'h0);

        // Main table
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VEC[i], i);
        end

        // R9: software reset clears everything in one cycle
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(bclk_out === 1'b0, "R9 bclk after soft reset", 32'(bclk_out), 32'h0);
        check(smp_valid === '0, "R9 valid after soft reset", 32'(smp_valid), 32'h0);
        check(smp_bit === '0, "R9 bits after soft reset", 32'(smp_bit), 32'h0);

        // R8 again after software reset
        ch_enable = '1;
        wait_bclk(1'b1);
        @(negedge clk);
        check(smp_valid === '0, "R8 no frame at first rise after soft reset",
              32'(smp_valid), 32'h0);

        // Capture resumes normally
        run_vec(VEC[0], 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule